// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block gates a group of clock outputs that all derive from one reference clock. An active-low stop request arrives with no timing relation to that clock. It is first synchronized into the reference domain. A run controller then decides whether the group runs or halts. One gate cell for each output passes or blocks the clock. Every gate cell samples its enable on the falling edge of the reference, so an output only ever changes state while the reference is low. A stopped output therefore sits at logic low. No high pulse is ever cut short, whether at stop or at restart.

The number of synchronizer stages and the minimum run length are parameters. One build suits a processor clock group: two stages, which gives a stop latency under four cycles, and a 100-cycle minimum run. Another build suits a bus clock group: one stage and a 10-cycle minimum run. A separate per-output enable, held in a configuration register, can keep an output low whatever the group state is. Clocks that are not part of the group never pass through this block.

There is no data stream, so there is no valid/ready handshake. Every pin is a plain control or status pin.

Top module: `clkstop_gate`

## Requirements
- R1: While rst_n is low, every bit of clk_out is low and running is high. After rst_n rises, the first clk_out pulse is a full high phase of clk_ref.
- R2: Suppose the minimum-run window has expired and stop_req_n is sampled low at rising edge k and stays low. Then running falls after rising edge k+SYNC_STAGES. The last output pulse is the one that starts at that edge. With 2 stages, the first missing pulse is at edge k+3, fewer than 4 cycles later.
- R3: While the group is halted, every clk_out bit is low in both phases of clk_ref.
- R4: Suppose stop_req_n is sampled high at rising edge a while the group is halted. Then running rises after edge a+SYNC_STAGES, and output pulses resume with a full-width pulse at edge a+SYNC_STAGES+1.
- R5: Once running rises, including at reset, it stays high for at least MIN_RUN cycles, whatever stop_req_n does.
- R6: A stop request that arrives during the minimum-run window is held pending. It halts the group at the first rising edge after the window ends, provided the synchronized request is still low at that edge.
- R7: out_en bit i controls only clk_out bit i. When out_en bit i is 0, clk_out bit i stays low and the other outputs are unaffected.
- R8: out_en is captured on the falling edge of clk_ref and takes effect from the next high phase. A clk_out bit rises only when clk_ref rises and falls only when clk_ref falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| out_en | input | N_OUT | Per-output enables from a configuration register, 1 = enabled |
| clk_out | output | N_OUT | Gated clock outputs |
| running | output | 1 | High while the group run state is active |

## Verification
The stop request reaches the run state SYNC_STAGES rising edges after it is sampled. A change in the run state or in an enable reaches clk_out in the high phase after the next falling edge. The bench keeps a cycle model that delays the request by SYNC_STAGES edges and delays the gate by one falling edge. It compares running 1 ns after each rising edge, compares clk_out in the same high phase, and checks that clk_out is zero in every low phase. Directed cases cover three situations: a request raised inside the minimum-run window, a single-cycle request pulse once the window has expired, and a change of enable. Random segments of stop level and enable pattern, drawn from a fixed seed, fill in the rest.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic {
    GS_HALT = 1'b0,
    GS_RUN  = 1'b1
  } gate_state_e;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  generate
    if (STAGES <= 1) begin : g_one
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= 1'b1;
        else        ff_q <= d_async;
      end
      assign q_sync = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
      assign q_sync = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/clkstop_run_ctl.sv
module clkstop_run_ctl
  import clkstop_pkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_seen,
  output logic run
);

  localparam int CW = cnt_width(MIN_RUN);
  localparam logic [CW-1:0] WIN_LOAD = CW'(MIN_RUN - 1);

  gate_state_e state_q, state_d;
  logic [CW-1:0] win_q, win_d;
  logic          win_open;

  assign win_open = (win_q != '0);

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    case (state_q)
      GS_RUN: begin
        if (win_open)       win_d   = win_q - 1'b1;
        else if (stop_seen) state_d = GS_HALT;
      end
      default: begin
        if (!stop_seen) begin
          state_d = GS_RUN;
          win_d   = WIN_LOAD;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_RUN;
      win_q   <= WIN_LOAD;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

  assign run = (state_q == GS_RUN);

endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic clk_o
);

  logic pass_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= run & en;
  end

  assign clk_o = clk & pass_q;

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_out,
  output logic             running
);

  logic req_n_sync;
  logic run_st;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .d_async (stop_req_n),
    .q_sync  (req_n_sync)
  );

  clkstop_run_ctl #(.MIN_RUN(MIN_RUN)) u_ctl (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .stop_seen (~req_n_sync),
    .run       (run_st)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_cell
      clkstop_gate_cell u_cell (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .run   (run_st),
        .en    (out_en[gi]),
        .clk_o (clk_out[gi])
      );
    end
  endgenerate

  assign running = run_st;

endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             stop_req_n,
  input logic [N_OUT-1:0] out_en,
  input logic [N_OUT-1:0] clk_out,
  input logic             running
);

  localparam int AW = $clog2(MIN_RUN + 2);
  localparam int HW = $clog2(SYNC_STAGES + 3);

  logic [AW-1:0] age_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      hi_q  <= '0;
    end else begin
      if (!running)                 age_q <= '0;
      else if (age_q < AW'(MIN_RUN)) age_q <= age_q + 1'b1;
      if (!stop_req_n)                   hi_q <= '0;
      else if (hi_q < HW'(SYNC_STAGES + 1)) hi_q <= hi_q + 1'b1;
    end
  end

  assert_min_run_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(running) |-> (age_q >= AW'(MIN_RUN)));

  assert_restart_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (hi_q >= HW'(SYNC_STAGES + 1)) |-> running);

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_chk
      assert_halt_low_R3: assert property (@(negedge clk_ref) disable iff (!rst_n)
        clk_out[gi] |-> $past(running));

      assert_en_gates_R7: assert property (@(negedge clk_ref) disable iff (!rst_n)
        clk_out[gi] |-> $past(out_en[gi]));

      always @(posedge clk_out[gi]) begin
        assert_rise_edge_R8: assert (clk_ref || !rst_n)
          else $error("clk_out rose while clk_ref low");
      end

      always @(negedge clk_out[gi]) begin
        assert_fall_edge_R8: assert (!clk_ref || !rst_n)
          else $error("clk_out fell while clk_ref high");
      end
    end
  endgenerate

endmodule

bind clkstop_gate clkstop_gate_chk #(
  .N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES), .MIN_RUN(MIN_RUN)
) u_chk (.*);

// File: tb/tb_clkstop_gate.sv
module tb_clkstop_gate;

  localparam int N  = 4;
  localparam int SY = 2;
  localparam int MR = 100;
  localparam logic [N-1:0] ALL1 = '1;

  logic         clk_ref = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_req_n = 1'b1;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] clk_out;
  logic         running;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // model state
  bit           m_run = 1;
  int           m_cnt = MR - 1;
  bit           hist [SY];
  bit           s_cur = 1;
  logic [N-1:0] en_cur = '1;
  logic [N-1:0] gate_prev = '0;
  string        gate_tag = "R1";
  bit           pend = 0;

  clkstop_gate #(.N_OUT(N), .SYNC_STAGES(SY), .MIN_RUN(MR)) dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .out_en(out_en), .clk_out(clk_out), .running(running)
  );

  always #2 clk_ref = ~clk_ref;

  function automatic logic [N-1:0] exp_gate(input bit run, input logic [N-1:0] en);
    return run ? en : '0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // one clock period: model the rising edge, check, drive next inputs, check low phase
  task automatic step(input bit nxt_s, input logic [N-1:0] nxt_en);
    bit    req;
    string rtag;
    @(posedge clk_ref); #1;
    req = !hist[SY-1];
    if (m_run && req && m_cnt != 0) rtag = "R5";
    else if (m_run && req) rtag = pend ? "R6" : "R2";
    else rtag = "R4";
    pend = m_run && req && (m_cnt != 0);
    if (m_run) begin
      if (m_cnt != 0) m_cnt--;
      else if (req) m_run = 0;
    end else if (!req) begin
      m_run = 1;
      m_cnt = MR - 1;
    end
    for (int j = SY - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = s_cur;
    check(rtag, {{(N-1){1'b0}}, running}, {{(N-1){1'b0}}, m_run});
    check(gate_tag, clk_out, gate_prev);
    stop_req_n = nxt_s;
    if (nxt_en != en_cur) gate_tag = "R8";
    else if (!m_run) gate_tag = "R3";
    else if (nxt_en != ALL1) gate_tag = "R7";
    else gate_tag = "R2";
    out_en    = nxt_en;
    s_cur     = nxt_s;
    en_cur    = nxt_en;
    gate_prev = exp_gate(m_run, nxt_en);
    #2;
    check("R3", clk_out, '0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int j = 0; j < SY; j++) hist[j] = 1;
    // R1: reset state
    for (int c = 0; c < 5; c++) begin
      @(posedge clk_ref); #1;
      check("R1", clk_out, '0);
      check("R1", {{(N-1){1'b0}}, running}, {{(N-1){1'b0}}, 1'b1});
    end
    rst_n = 1'b1;
    gate_prev = exp_gate(m_run, en_cur);
    gate_tag  = "R1";
    #2;
    check("R1", clk_out, '0);
    // R5/R6: request raised inside the reset window, held past expiry
    for (int c = 0; c < 10; c++) step(1, ALL1);
    for (int c = 0; c < 130; c++) step(0, ALL1);
    // R4: restart, then R5 again with an early request
    for (int c = 0; c < 20; c++) step(1, ALL1);
    for (int c = 0; c < 110; c++) step(0, ALL1);
    // R7/R8: partial enables while running
    for (int c = 0; c < 110; c++) step(1, 4'b0101);
    for (int c = 0; c < 6; c++) step(1, 4'b1010);
    step(1, 4'b0000);
    step(1, ALL1);
    // R2: single-cycle stop pulse after the window has expired
    step(0, ALL1);
    for (int c = 0; c < 120; c++) step(1, ALL1);
    // random segments
    for (int sg = 0; sg < 70; sg++) begin
      bit           s  = $urandom_range(0, 1);
      int           ln = $urandom_range(1, 120);
      logic [N-1:0] en = ($urandom_range(0, 3) != 0) ? ALL1 : N'($urandom);
      for (int c = 0; c < ln; c++) step(s, en);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule